// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block takes an incoming packet, presented one byte per handshake, and scatters it into host buffers. The buffers are listed in a circular ring of 16-byte descriptors held in host memory. Software programs the ring's byte length, a head index and a tail index through a small configuration write port. It also supplies the ring base address and the receive control word as plain inputs. Each fragment starts with a check that a free descriptor exists. The block then fetches the 64-bit buffer pointer from the descriptor. It streams up to one buffer's worth of packet bytes into the buffer as 32-bit words, and writes back the fragment length and a status word. Finally it moves the head forward, wrapping at the end of the ring.

The buffer size comes from a 2-bit code and an extension bit in the control word. A packet longer than one buffer spreads over several consecutive descriptors. If the ring runs dry before a fragment starts, the block raises an overrun event and discards the rest of that packet. The last fragment of a completed packet raises a receive-timer event. Both events are single-cycle pulses meant for a separate interrupt unit. All descriptor and buffer traffic uses one word-wide request port that completes on an acknowledge.

Top module: `rxring_writer`

## Requirements
- R1: Packets are accepted only while bit 1 of `rxCtrl` is set. While it is clear and no packet is in progress, `pktReady` stays low and no memory request is made.
- R2: The buffer size is decoded from `rxCtrl[17:16]` (code) and `rxCtrl[25]` (extension). Without the extension, codes 0/1/2/3 select 2048/1024/512/256 bytes. With the extension, codes 1/2/3 select 16384/8192/4096 bytes.
- R3: Extension set with code 0 is an invalid size. In that case packets are refused: `pktReady` stays low, no memory traffic occurs and the head does not move.
- R4: The descriptor at index `head` lives at `ringBase + 16*head`. Byte offsets 0 and 4 give the low and high 32 bits of the buffer address. Offset 8 receives the written length and offset 12 receives the status.
- R5: Each fragment holds at most the buffer size. Its bytes are written little-endian into consecutive 32-bit words from the buffer start, and unused bytes of the final word are written as zero. A fragment that does not end the packet has status 0x5 (done bit 0, ignore-checksum bit 2) and length equal to its byte count.
- R6: The fragment that ends the packet has status 0x7 (end-of-packet bit 1 added) and length equal to its byte count plus 4. It produces one `evRxTimer` pulse.
- R7: After each descriptor write-back the head increments, and it becomes 0 when it reaches ring length / 16.
- R8: Configuration writes are selected by `cfgSel`: 0 = ring length, 1 = head, 2 = tail, 3 = no effect. A ring length write keeps only bits 19:7. Head and tail writes keep only bits 15:0.
- R9: If head equals tail when a fragment is about to start, one `evOverrun` pulse is produced. The remaining bytes of the packet are accepted and discarded with no memory writes, and no `evRxTimer` pulse occurs.
- R10: A memory request keeps its address, write data and write enable unchanged until `memAck`.
- R11: During reset the head index and ring length read 0, and `pktReady` and `memReq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxCtrl | input | 32 | Receive control word (enable, size code, extension) |
| ringBase | input | 64 | Byte address of descriptor 0 |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Configuration target: 0 length, 1 head, 2 tail |
| cfgWdata | input | 32 | Configuration write value |
| pktValid | input | 1 | Packet byte present |
| pktData | input | 8 | Packet byte |
| pktLast | input | 1 | Byte is the last of its packet |
| pktReady | output | 1 | Byte taken on this edge when valid |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Request is a write |
| memAddr | output | 64 | Byte address of the word |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid with memAck |
| memAck | input | 1 | Request completed |
| headIdx | output | 16 | Current head index |
| ringLenBytes | output | 32 | Stored ring length in bytes |
| evOverrun | output | 1 | One-cycle overrun event |
| evRxTimer | output | 1 | One-cycle packet-complete event |

## Verification
Some properties are checked on every cycle. These are the stability of a pending memory request, the legal bit range of the stored ring length, the single-step and wrap movement of the head after each write-back, the shape of every status write, and the silence of the memory port while a packet is being discarded. The assertions also hold the idle state still while the receiver is off or the size is invalid. Other behaviour can only be shown by the bench's scenarios. These are the split points for each buffer size, byte placement and zero padding in host memory, the final length with its FCS allowance, the head's position after wrapping, and the exact write count when the ring runs dry partway through a packet or before it starts.

// File: rtl/rxring_pkg.sv
package rxring_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_DESC_LO, S_DESC_HI, S_FILL, S_DATA, S_LEN, S_STAT, S_NEXT, S_DROP
  } phase_t;

  typedef enum logic [2:0] {
    SEL_DESC_LO, SEL_DESC_HI, SEL_LEN, SEL_STAT, SEL_DATA
  } memsel_t;

  typedef struct packed {
    logic    req;
    logic    we;
    memsel_t sel;
    logic    startFrag;
    logic    ldLo;
    logic    ldHi;
    logic    takeByte;
    logic    clrWord;
    logic    advHead;
    logic    raiseOverrun;
    logic    raiseTimer;
  } strobe_t;

  // 0 means the code is not a usable size
  function automatic logic [15:0] decodeBufSize(input logic ext, input logic [1:0] code);
    if (!ext) return 16'd2048 >> code;
    if (code == 2'd0) return 16'd0;
    return 16'd32768 >> code;
  endfunction

endpackage

// File: rtl/rxring_ctrl.sv
module rxring_ctrl
  import rxring_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    pktValid,
  input  logic    pktLast,
  input  logic    rxEn,
  input  logic    sizeOk,
  input  logic    headEqTail,
  input  logic    closesWord,
  input  logic    fragEnd,
  input  logic    pktEnd,
  input  logic    memAck,
  output strobe_t stb,
  output logic    pktReady,
  output phase_t  phase
);

  phase_t nxt;

  always_ff @(posedge clk) begin
    if (!rstN) phase <= S_IDLE;
    else       phase <= nxt;
  end

  always_comb begin
    nxt      = phase;
    stb      = '0;
    stb.sel  = SEL_DESC_LO;
    pktReady = 1'b0;
    unique case (phase)
      S_IDLE: begin
        if (pktValid && rxEn && sizeOk) begin
          if (headEqTail) begin
            stb.raiseOverrun = 1'b1;
            nxt = S_DROP;
          end else begin
            stb.startFrag = 1'b1;
            nxt = S_DESC_LO;
          end
        end
      end
      S_DESC_LO: begin
        stb.req = 1'b1;
        stb.sel = SEL_DESC_LO;
        if (memAck) begin
          stb.ldLo = 1'b1;
          nxt = S_DESC_HI;
        end
      end
      S_DESC_HI: begin
        stb.req = 1'b1;
        stb.sel = SEL_DESC_HI;
        if (memAck) begin
          stb.ldHi = 1'b1;
          nxt = S_FILL;
        end
      end
      S_FILL: begin
        pktReady = 1'b1;
        if (pktValid) begin
          stb.takeByte = 1'b1;
          if (closesWord) nxt = S_DATA;
        end
      end
      S_DATA: begin
        stb.req = 1'b1;
        stb.we  = 1'b1;
        stb.sel = SEL_DATA;
        if (memAck) begin
          stb.clrWord = 1'b1;
          nxt = fragEnd ? S_LEN : S_FILL;
        end
      end
      S_LEN: begin
        stb.req = 1'b1;
        stb.we  = 1'b1;
        stb.sel = SEL_LEN;
        if (memAck) nxt = S_STAT;
      end
      S_STAT: begin
        stb.req = 1'b1;
        stb.we  = 1'b1;
        stb.sel = SEL_STAT;
        if (memAck) begin
          stb.advHead    = 1'b1;
          stb.raiseTimer = pktEnd;
          nxt = pktEnd ? S_IDLE : S_NEXT;
        end
      end
      S_NEXT: begin
        if (headEqTail) begin
          stb.raiseOverrun = 1'b1;
          nxt = S_DROP;
        end else begin
          stb.startFrag = 1'b1;
          nxt = S_DESC_LO;
        end
      end
      S_DROP: begin
        pktReady = 1'b1;
        if (pktValid && pktLast) nxt = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

endmodule

// File: rtl/rxring_datapath.sv
module rxring_datapath
  import rxring_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int IDX_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [15:0]       bufSize,
  input  logic [ADDR_W-1:0] ringBase,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [31:0]       cfgWdata,
  input  logic [7:0]        pktData,
  input  logic              pktLast,
  input  logic [31:0]       memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  output logic              headEqTail,
  output logic              closesWord,
  output logic              fragEnd,
  output logic              pktEnd,
  output logic [IDX_W-1:0]  headIdx,
  output logic [31:0]       ringLenBytes,
  output logic              evOverrun,
  output logic              evRxTimer
);

  localparam int          DESC_SHIFT = 4;
  localparam logic [31:0] LEN_MASK   = ((32'd1 << (IDX_W + DESC_SHIFT)) - 32'd1) & ~32'd127;
  localparam logic [31:0] ST_DONE    = 32'h1;
  localparam logic [31:0] ST_EOP     = 32'h2;
  localparam logic [31:0] ST_NOCSUM  = 32'h4;

  logic [IDX_W-1:0]  tailIdx, entries, headInc;
  logic [ADDR_W-1:0] bufAddr, descAddr;
  logic [15:0]       byteCnt, wordOff;
  logic [31:0]       wordAsm;

  assign entries    = ringLenBytes[IDX_W+DESC_SHIFT-1:DESC_SHIFT];
  assign headInc    = headIdx + IDX_W'(1);
  assign headEqTail = (headIdx == tailIdx);
  assign closesWord = (byteCnt[1:0] == 2'd3) || pktLast || (byteCnt + 16'd1 == bufSize);
  assign descAddr   = ringBase + (ADDR_W'(headIdx) << DESC_SHIFT);

  always_comb begin
    memAddr  = descAddr;
    memWdata = '0;
    unique case (stb.sel)
      SEL_DESC_LO: memAddr = descAddr;
      SEL_DESC_HI: memAddr = descAddr + ADDR_W'(4);
      SEL_LEN: begin
        memAddr  = descAddr + ADDR_W'(8);
        memWdata = 32'(byteCnt) + (pktEnd ? 32'd4 : 32'd0);
      end
      SEL_STAT: begin
        memAddr  = descAddr + ADDR_W'(12);
        memWdata = ST_DONE | ST_NOCSUM | (pktEnd ? ST_EOP : 32'd0);
      end
      SEL_DATA: begin
        memAddr  = bufAddr + ADDR_W'(wordOff);
        memWdata = wordAsm;
      end
      default: memAddr = descAddr;
    endcase
  end

  // ring registers: software write to head outranks the advance
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ringLenBytes <= '0;
      headIdx      <= '0;
      tailIdx      <= '0;
    end else begin
      if (cfgWe && cfgSel == 2'd0) ringLenBytes <= cfgWdata & LEN_MASK;
      if (cfgWe && cfgSel == 2'd2) tailIdx <= cfgWdata[IDX_W-1:0];
      if (cfgWe && cfgSel == 2'd1)  headIdx <= cfgWdata[IDX_W-1:0];
      else if (stb.advHead)         headIdx <= (headInc == entries) ? '0 : headInc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufAddr   <= '0;
      byteCnt   <= '0;
      wordOff   <= '0;
      wordAsm   <= '0;
      fragEnd   <= 1'b0;
      pktEnd    <= 1'b0;
      evOverrun <= 1'b0;
      evRxTimer <= 1'b0;
    end else begin
      evOverrun <= stb.raiseOverrun;
      evRxTimer <= stb.raiseTimer;
      if (stb.ldLo) bufAddr[31:0] <= memRdata;
      if (stb.ldHi) bufAddr[ADDR_W-1:32] <= memRdata[ADDR_W-33:0];
      if (stb.startFrag) begin
        byteCnt <= '0;
        wordOff <= '0;
        wordAsm <= '0;
        fragEnd <= 1'b0;
        pktEnd  <= 1'b0;
      end else if (stb.takeByte) begin
        wordAsm[{byteCnt[1:0], 3'b000} +: 8] <= pktData;
        byteCnt <= byteCnt + 16'd1;
        fragEnd <= pktLast || (byteCnt + 16'd1 == bufSize);
        pktEnd  <= pktLast;
      end else if (stb.clrWord) begin
        wordAsm <= '0;
        wordOff <= wordOff + 16'd4;
      end
    end
  end

endmodule

// File: rtl/rxring_writer.sv
module rxring_writer
  import rxring_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int IDX_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [31:0]       rxCtrl,
  input  logic [ADDR_W-1:0] ringBase,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [31:0]       cfgWdata,
  input  logic              pktValid,
  input  logic [7:0]        pktData,
  input  logic              pktLast,
  output logic              pktReady,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  input  logic              memAck,
  output logic [IDX_W-1:0]  headIdx,
  output logic [31:0]       ringLenBytes,
  output logic              evOverrun,
  output logic              evRxTimer
);

  localparam int EN_BIT   = 1;
  localparam int CODE_LSB = 16;
  localparam int EXT_BIT  = 25;

  strobe_t     stb;
  phase_t      phase;
  logic [15:0] bufSize;
  logic        headEqTail, closesWord, fragEnd, pktEnd;

  assign bufSize = decodeBufSize(rxCtrl[EXT_BIT], rxCtrl[CODE_LSB+1:CODE_LSB]);
  assign memReq  = stb.req;
  assign memWe   = stb.we;

  rxring_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .pktValid(pktValid), .pktLast(pktLast),
    .rxEn(rxCtrl[EN_BIT]), .sizeOk(bufSize != 16'd0), .headEqTail(headEqTail),
    .closesWord(closesWord), .fragEnd(fragEnd), .pktEnd(pktEnd), .memAck(memAck),
    .stb(stb), .pktReady(pktReady), .phase(phase)
  );

  rxring_datapath #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .bufSize(bufSize), .ringBase(ringBase),
    .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgWdata(cfgWdata), .pktData(pktData),
    .pktLast(pktLast), .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata),
    .headEqTail(headEqTail), .closesWord(closesWord), .fragEnd(fragEnd),
    .pktEnd(pktEnd), .headIdx(headIdx), .ringLenBytes(ringLenBytes),
    .evOverrun(evOverrun), .evRxTimer(evRxTimer)
  );

endmodule

// File: rtl/rxring_writer_chk.sv
module rxring_writer_chk
  import rxring_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int IDX_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [31:0]       rxCtrl,
  input logic              cfgWe,
  input logic [1:0]        cfgSel,
  input logic              pktReady,
  input logic              memReq,
  input logic              memWe,
  input logic              memAck,
  input logic [ADDR_W-1:0] memAddr,
  input logic [31:0]       memWdata,
  input logic [IDX_W-1:0]  headIdx,
  input logic [31:0]       ringLenBytes,
  input phase_t            phase,
  input strobe_t           stb
);

  logic headWrite, wrapNow;
  assign headWrite = cfgWe && (cfgSel == 2'd1);
  assign wrapNow   = (ringLenBytes[IDX_W+3:4] == headIdx + IDX_W'(1));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWdata) && $stable(memWe));

  assert_off_stays_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    phase == S_IDLE && !rxCtrl[1] |=> phase == S_IDLE);

  assert_bad_size_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    phase == S_IDLE && rxCtrl[25] && rxCtrl[17:16] == 2'd0 |=> phase == S_IDLE);

  assert_len_bits_R8: assert property (@(posedge clk) disable iff (!rstN)
    ringLenBytes[6:0] == 7'd0 && ringLenBytes[31:20] == 12'd0);

  assert_head_wrap_R7: assert property (@(posedge clk) disable iff (!rstN)
    stb.advHead && !headWrite && wrapNow |=> headIdx == '0);

  assert_head_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    stb.advHead && !headWrite && !wrapNow |=> headIdx == $past(headIdx) + IDX_W'(1));

  assert_status_shape_R5: assert property (@(posedge clk) disable iff (!rstN)
    phase == S_STAT && memReq |-> memWe && memWdata[0] && memWdata[2] && memWdata[31:3] == '0);

  assert_drop_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    phase == S_DROP |-> !memReq);

endmodule

bind rxring_writer rxring_writer_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/sim_rxring_writer.sv
`timescale 1ns/1ps
module sim_rxring_writer;

  localparam int NV = 9;
  localparam int VLEN  [NV] = '{600, 513, 5, 100, 70, 257, 256, 1, 4};
  localparam int VCODE [NV] = '{3,   2,   1, 0,   3,  1,   3,   3, 3};
  localparam int VEXT  [NV] = '{0,   0,   0, 0,   1,  1,   0,   0, 0};
  localparam int RING  = 8;
  localparam logic [31:0] DBASE = 32'h100;
  localparam logic [31:0] BBASE = 32'h1000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] rxCtrl = '0;
  logic [63:0] ringBase = 64'h100;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgSel = '0;
  logic [31:0] cfgWdata = '0;
  logic        pktValid = 1'b0;
  logic [7:0]  pktData = '0;
  logic        pktLast = 1'b0;
  logic        pktReady, memReq, memWe, memAck, evOverrun, evRxTimer;
  logic [63:0] memAddr;
  logic [31:0] memWdata, memRdata, ringLenBytes;
  logic [15:0] headIdx;

  int nChk = 0, nFail = 0;
  int wrCount = 0, badHi = 0, ovCnt = 0, tmCnt = 0;
  logic [31:0] mem [0:4095];
  logic ackR = 1'b0;
  logic [31:0] rdR = '0;

  always #2 clk = ~clk;

  assign memAck   = ackR;
  assign memRdata = rdR;

  rxring_writer u0 (
    .clk(clk), .rstN(rstN), .rxCtrl(rxCtrl), .ringBase(ringBase), .cfgWe(cfgWe),
    .cfgSel(cfgSel), .cfgWdata(cfgWdata), .pktValid(pktValid), .pktData(pktData),
    .pktLast(pktLast), .pktReady(pktReady), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata), .memAck(memAck),
    .headIdx(headIdx), .ringLenBytes(ringLenBytes), .evOverrun(evOverrun),
    .evRxTimer(evRxTimer)
  );

  // host memory: one-cycle acknowledge; buffer pointers carry high word 1
  always @(posedge clk) begin
    if (memReq && !ackR) begin
      ackR <= 1'b1;
      if (memAddr[31:0] >= BBASE ? memAddr[63:32] != 32'd1 : memAddr[63:32] != 32'd0)
        badHi <= badHi + 1;
      if (memWe) begin
        mem[memAddr[13:2]] <= memWdata;
        wrCount <= wrCount + 1;
      end else begin
        rdR <= mem[memAddr[13:2]];
      end
    end else begin
      ackR <= 1'b0;
    end
    if (evOverrun) ovCnt <= ovCnt + 1;
    if (evRxTimer) tmCnt <= tmCnt + 1;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int bufBytes(input int ext, input int code);
    case ({ext[0], code[1:0]})
      3'b000: return 2048;
      3'b001: return 1024;
      3'b010: return 512;
      3'b011: return 256;
      3'b100: return 0;
      3'b101: return 16384;
      3'b110: return 8192;
      default: return 4096;
    endcase
  endfunction

  function automatic logic [31:0] descWord(input int d, input int k);
    return mem[(DBASE + d*16 + k*4) >> 2];
  endfunction

  function automatic logic [7:0] memByte(input int addr);
    logic [31:0] w;
    w = mem[addr >> 2];
    return w[8*(addr % 4) +: 8];
  endfunction

  task automatic cfgWrite(input logic [1:0] sel, input logic [31:0] val);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = sel; cfgWdata = val;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic sendPkt(input int id, input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      pktValid = 1'b1;
      pktData  = 8'((id * 7 + i) & 255);
      pktLast  = (i == len - 1);
      while (!pktReady) @(negedge clk);
    end
    @(negedge clk);
    pktValid = 1'b0;
    pktLast  = 1'b0;
    repeat (40) @(negedge clk);
  endtask

  task automatic prepRing();
    for (int d = 0; d < RING; d++) begin
      mem[(DBASE + d*16 + 8) >> 2]  = '0;
      mem[(DBASE + d*16 + 12) >> 2] = '0;
      for (int w = 0; w < 256; w++) mem[(BBASE + d*32'h400) / 4 + w] = 32'hFFFF_FFFF;
    end
  endtask

  task automatic finish();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish();
  end

  initial begin
    int hExp, w0, o0, t0;
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    for (int d = 0; d < RING; d++) begin
      mem[(DBASE + d*16) >> 2]     = BBASE + d*32'h400;
      mem[(DBASE + d*16 + 4) >> 2] = 32'd1;
    end
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 head", 64'(headIdx), 64'd0);
    chk("R11 len", 64'(ringLenBytes), 64'd0);
    chk("R11 ready/req", {62'd0, pktReady, memReq}, 64'd0);
    rstN = 1'b1;

    // R8 field masking and select decode
    cfgWrite(2'd0, 32'hFFFF_FFFF);
    chk("R8 ring length mask", 64'(ringLenBytes), 64'h000F_FF80);
    cfgWrite(2'd1, 32'h0001_2345);
    chk("R8 head mask", 64'(headIdx), 64'h2345);
    cfgWrite(2'd3, 32'h0000_0000);
    chk("R8 sel3 no effect", {32'(ringLenBytes), 16'd0, headIdx}, {32'h000F_FF80, 16'd0, 16'h2345});
    cfgWrite(2'd0, 32'd128);
    cfgWrite(2'd1, 32'd0);
    cfgWrite(2'd2, 32'd4);

    // R1 receiver off, R3 invalid size: nothing is taken
    for (int pass = 0; pass < 2; pass++) begin
      int seen;
      rxCtrl = (pass == 0) ? 32'h0 : (32'h2 | (32'h1 << 25));
      w0 = wrCount; seen = 0;
      @(negedge clk);
      pktValid = 1'b1; pktData = 8'hA5;
      repeat (20) begin
        @(negedge clk);
        if (pktReady || memReq) seen++;
      end
      pktValid = 1'b0;
      repeat (4) @(negedge clk);
      chk(pass == 0 ? "R1 ignored while off" : "R3 invalid size refused",
          {32'(seen), 32'(wrCount - w0)}, 64'd0);
      chk(pass == 0 ? "R1 head still" : "R3 head still", 64'(headIdx), 64'd0);
    end

    // vector table: sizes, splits, padding, wrap
    hExp = 0;
    for (int v = 0; v < NV; v++) begin
      int bsz, nFrag, rem, h0;
      h0 = hExp;
      bsz = bufBytes(VEXT[v], VCODE[v]);
      nFrag = (VLEN[v] + bsz - 1) / bsz;
      prepRing();
      cfgWrite(2'd2, 32'((h0 + 7) % RING));
      rxCtrl = 32'h2 | (32'(VCODE[v]) << 16) | (32'(VEXT[v]) << 25);
      t0 = tmCnt;
      sendPkt(v, VLEN[v]);
      rem = VLEN[v];
      for (int f = 0; f < nFrag; f++) begin
        int d, fl, bad, base;
        logic last;
        d = (h0 + f) % RING;
        fl = (rem > bsz) ? bsz : rem;
        last = (f == nFrag - 1);
        base = BBASE + d*32'h400;
        bad = 0;
        for (int b = 0; b < fl; b++)
          if (memByte(base + b) !== 8'((v * 7 + (VLEN[v] - rem) + b) & 255)) bad++;
        for (int b = fl; b % 4 != 0; b++)
          if (memByte(base + b) !== 8'h00) bad++;
        chk(last ? "R6 final length +4" : "R5 fragment length", 64'(descWord(d, 2)), 64'(fl + (last ? 4 : 0)));
        chk(last ? "R6 final status" : "R5 status", 64'(descWord(d, 3)), last ? 64'h7 : 64'h5);
        chk("R5 R2 data and padding", 64'(bad), 64'd0);
        rem -= fl;
      end
      hExp = (h0 + nFrag) % RING;
      chk("R7 head after packet", 64'(headIdx), 64'(hExp));
      chk("R6 timer event", 64'(tmCnt - t0), 64'd1);
    end
    chk("R4 address halves", 64'(badHi), 64'd0);

    // R9 ring runs dry after one fragment
    prepRing();
    cfgWrite(2'd2, 32'((hExp + 1) % RING));
    rxCtrl = 32'h2 | (32'd3 << 16);
    o0 = ovCnt; t0 = tmCnt; w0 = wrCount;
    sendPkt(20, 600);
    chk("R9 overrun mid packet", 64'(ovCnt - o0), 64'd1);
    chk("R9 no timer", 64'(tmCnt - t0), 64'd0);
    chk("R9 writes only first fragment", 64'(wrCount - w0), 64'd66);
    chk("R9 first fragment status", 64'(descWord(hExp, 3)), 64'h5);
    chk("R9 first fragment length", 64'(descWord(hExp, 2)), 64'd256);
    hExp = (hExp + 1) % RING;
    chk("R9 R7 head", 64'(headIdx), 64'(hExp));

    // R9 ring empty at packet start
    o0 = ovCnt; w0 = wrCount;
    sendPkt(21, 10);
    chk("R9 overrun at start", 64'(ovCnt - o0), 64'd1);
    chk("R9 nothing written", 64'(wrCount - w0), 64'd0);
    chk("R9 head unchanged", 64'(headIdx), 64'(hExp));

    // recovery after more descriptors are posted
    prepRing();
    cfgWrite(2'd2, 32'((hExp + 3) % RING));
    sendPkt(22, 8);
    chk("R6 recovery length", 64'(descWord(hExp, 2)), 64'd12);
    chk("R7 recovery head", 64'(headIdx), 64'((hExp + 1) % RING));
    finish();
  end

endmodule